// File: doc/BRIEF.md
# Condition Register File with Same-Cycle Forwarding

This block holds the condition word of a processor core: one 32-bit register, treated as eight 4-bit fields. Two producers can ask to write it. The execute path and the multiply path each present a valid bit, a condition-write enable, a per-field mask and a full-width data word. A fixed-priority arbiter picks one request and turns it into a single write port. If both qualify in the same cycle, the multiply path wins. If neither qualifies, the port stays idle.

The register is kept as a single word with a write enable for each nibble. A merge stage builds the next value nibble by nibble. A nibble comes from the write data when the port is enabled and its mask bit is set. Every other nibble comes from the stored word. The merged word drives the read port straight away, so a consumer in the same cycle already sees the fields being written. The same word is loaded into the storage on the next rising edge.

Top module: `cond_reg_file`

## Requirements
- R1: A synchronous active-high `rst` clears the stored word to zero. With no write requested, the read port then returns 0.
- R2: When the write port is enabled, every nibble whose mask bit is set shows the write data on `rd_word` in the same cycle, before any clock edge.
- R3: A nibble whose mask bit is clear keeps its stored value, both on the read port in that cycle and in storage after the edge.
- R4: After a rising edge without reset, the stored word equals the value `rd_word` showed just before that edge. It can be read back in the next idle cycle.
- R5: When both producers are valid with their condition enable set, the multiply request's mask and data are used and the execute request is dropped.
- R6: When only the execute producer is valid with its condition enable set, its mask and data are written.
- R7: A producer whose valid bit or condition enable is low has no effect. With neither qualifying, the port stays idle and no field changes.
- R8: Mask bit i selects bits 4i+3 down to 4i. Bit 0 is the lowest nibble and bit 7 is the highest.
- R9: An enabled write with an all-zero mask changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exe_valid | input | 1 | Execute result valid |
| exe_cr_en | input | 1 | Execute result writes the condition word |
| exe_mask | input | 8 | Execute field mask, bit i for nibble i |
| exe_data | input | 32 | Execute condition data |
| mul_valid | input | 1 | Multiply result valid |
| mul_cr_en | input | 1 | Multiply result writes the condition word |
| mul_mask | input | 8 | Multiply field mask, bit i for nibble i |
| mul_data | input | 32 | Multiply condition data |
| rd_word | output | 32 | Condition word with this cycle's write forwarded |

## Verification
The bench builds the block with its default of eight 4-bit fields. At this size every mask bit, including the lowest and highest nibble boundaries, can be reached by directed vectors. The all-zero and all-one masks are also covered. A reference model predicts the forwarded word in every cycle. Random back-to-back writes from both producers, with each producer's valid and enable bits varied independently, check the priority rule and the storage of the previous cycle together.

// File: rtl/cr_pkg.sv
package cr_pkg;
  parameter int CR_FIELDS  = 8;
  parameter int CR_FIELD_W = 4;
  localparam int CR_W = CR_FIELDS * CR_FIELD_W;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXE  = 2'd1,
    SRC_MUL  = 2'd2
  } cr_src_e;
endpackage

// File: rtl/cr_wr_arbiter.sv
module cr_wr_arbiter
  import cr_pkg::*;
#(
  parameter int NF = CR_FIELDS,
  parameter int FW = CR_FIELD_W,
  localparam int W = NF * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exe_valid,
  input  logic          exe_cr_en,
  input  logic [NF-1:0] exe_mask,
  input  logic [W-1:0]  exe_data,
  input  logic          mul_valid,
  input  logic          mul_cr_en,
  input  logic [NF-1:0] mul_mask,
  input  logic [W-1:0]  mul_data,
  output logic          wr_en,
  output logic [NF-1:0] wr_mask,
  output logic [W-1:0]  wr_data
);
  cr_src_e src;
  logic    exe_req, mul_req;

  assign exe_req = exe_valid & exe_cr_en;
  assign mul_req = mul_valid & mul_cr_en;

  always_comb begin
    if (mul_req)      src = SRC_MUL;
    else if (exe_req) src = SRC_EXE;
    else              src = SRC_NONE;
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_mask = '0;
    wr_data = '0;
    case (src)
      SRC_MUL: begin
        wr_en   = 1'b1;
        wr_mask = mul_mask;
        wr_data = mul_data;
      end
      SRC_EXE: begin
        wr_en   = 1'b1;
        wr_mask = exe_mask;
        wr_data = exe_data;
      end
      default: ;
    endcase
  end

  // Multiply request overrides execute when both qualify
  assert_mul_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (exe_valid && exe_cr_en && mul_valid && mul_cr_en)
      |-> (wr_en && wr_mask == mul_mask && wr_data == mul_data));

  // No qualifying producer leaves the port idle
  assert_idle_port_R7: assert property (@(posedge clk) disable iff (rst)
    !(exe_valid && exe_cr_en) && !(mul_valid && mul_cr_en) |-> !wr_en);
endmodule

// File: rtl/cr_nibble_merge.sv
module cr_nibble_merge
  import cr_pkg::*;
#(
  parameter int NF = CR_FIELDS,
  parameter int FW = CR_FIELD_W,
  localparam int W = NF * FW
) (
  input  logic          wr_en,
  input  logic [NF-1:0] wr_mask,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  stored,
  output logic [W-1:0]  merged,
  output logic [W-1:0]  lane_sel
);
  for (genvar i = 0; i < NF; i++) begin : g_lane
    logic take;
    assign take = wr_en & wr_mask[i];
    assign lane_sel[i*FW +: FW] = {FW{take}};
    assign merged[i*FW +: FW]   = take ? wr_data[i*FW +: FW] : stored[i*FW +: FW];
  end
endmodule

// File: rtl/cr_store.sv
module cr_store
  import cr_pkg::*;
#(
  parameter int W = CR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/cond_reg_file.sv
module cond_reg_file
  import cr_pkg::*;
#(
  parameter int NF = CR_FIELDS,
  parameter int FW = CR_FIELD_W,
  localparam int W = NF * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exe_valid,
  input  logic          exe_cr_en,
  input  logic [NF-1:0] exe_mask,
  input  logic [W-1:0]  exe_data,
  input  logic          mul_valid,
  input  logic          mul_cr_en,
  input  logic [NF-1:0] mul_mask,
  input  logic [W-1:0]  mul_data,
  output logic [W-1:0]  rd_word
);
  logic          wr_en;
  logic [NF-1:0] wr_mask;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  stored;
  logic [W-1:0]  merged;
  logic [W-1:0]  lane_sel;

  cr_wr_arbiter #(.NF(NF), .FW(FW)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .exe_valid (exe_valid),
    .exe_cr_en (exe_cr_en),
    .exe_mask  (exe_mask),
    .exe_data  (exe_data),
    .mul_valid (mul_valid),
    .mul_cr_en (mul_cr_en),
    .mul_mask  (mul_mask),
    .mul_data  (mul_data),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data)
  );

  cr_nibble_merge #(.NF(NF), .FW(FW)) u_merge (
    .wr_en    (wr_en),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .stored   (stored),
    .merged   (merged),
    .lane_sel (lane_sel)
  );

  cr_store #(.W(W)) u_store (
    .clk (clk),
    .rst (rst),
    .d   (merged),
    .q   (stored)
  );

  assign rd_word = merged;

  // Reset leaves a cleared word
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;
  always_ff @(posedge clk) begin
    if (rst_q) assert_reset_clear_R1: assert (stored == '0);
  end

  // Selected lanes carry write data on the read port
  assert_forward_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((rd_word & lane_sel) == (wr_data & lane_sel)));

  // Unselected lanes of storage are untouched across an edge
  assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stored ^ $past(stored)) & ~$past(lane_sel)) == '0));

  // Idle port keeps the whole word
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (stored == $past(stored)));
endmodule

// File: tb/sim_cond_reg_file.sv
module sim_cond_reg_file;
  localparam int NF = 8;
  localparam int FW = 4;
  localparam int W  = NF * FW;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exe_valid = 0, exe_cr_en = 0, mul_valid = 0, mul_cr_en = 0;
  logic [NF-1:0] exe_mask = '0, mul_mask = '0;
  logic [W-1:0]  exe_data = '0, mul_data = '0;
  logic [W-1:0]  rd_word;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  cond_reg_file u0 (
    .clk(clk), .rst(rst),
    .exe_valid(exe_valid), .exe_cr_en(exe_cr_en), .exe_mask(exe_mask), .exe_data(exe_data),
    .mul_valid(mul_valid), .mul_cr_en(mul_cr_en), .mul_mask(mul_mask), .mul_data(mul_data),
    .rd_word(rd_word)
  );

  // {exe_valid, exe_cr_en, exe_mask, exe_data, mul_valid, mul_cr_en, mul_mask, mul_data}
  localparam logic [83:0] TBL [0:NV-1] = '{
    {1'b1, 1'b1, 8'hFF, 32'h1234_5678, 1'b0, 1'b0, 8'h00, 32'h0000_0000},
    {1'b1, 1'b1, 8'h01, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'h00, 32'h0000_0000},
    {1'b1, 1'b1, 8'h80, 32'h0000_0000, 1'b0, 1'b0, 8'h00, 32'h0000_0000},
    {1'b1, 1'b1, 8'hFF, 32'hAAAA_AAAA, 1'b1, 1'b1, 8'h0F, 32'h5555_5555},
    {1'b1, 1'b0, 8'hFF, 32'h0000_0000, 1'b0, 1'b0, 8'h00, 32'h0000_0000},
    {1'b0, 1'b1, 8'hFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'hFF, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b1, 8'hA5, 32'h9ABC_DEF0}
  };
  localparam string TAG [0:NV-1] = '{"R6", "R8", "R8", "R5", "R7", "R7", "R9", "R3"};

  function automatic logic [W-1:0] predict(input logic [W-1:0] cur);
    logic [W-1:0]  r = cur;
    logic          en;
    logic [NF-1:0] m;
    logic [W-1:0]  d;
    en = 1'b0; m = '0; d = '0;
    if (mul_valid && mul_cr_en)      begin en = 1'b1; m = mul_mask; d = mul_data; end
    else if (exe_valid && exe_cr_en) begin en = 1'b1; m = exe_mask; d = exe_data; end
    if (en)
      for (int i = 0; i < NF; i++)
        if (m[i]) r[i*FW +: FW] = d[i*FW +: FW];
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (rd_word !== exp) begin
      errors++;
      $display("FAIL %s: rd_word=%h expected=%h", tag, rd_word, exp);
    end
  endtask

  task automatic idle();
    exe_valid = 0; exe_cr_en = 0; mul_valid = 0; mul_cr_en = 0;
    exe_mask = '0; mul_mask = '0; exe_data = '0; mul_data = '0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: rd_word=%h expected=completion", rd_word);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] exp;
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R1", '0);

    // table walk: forward in cycle, stored value next idle cycle
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {exe_valid, exe_cr_en, exe_mask, exe_data,
       mul_valid, mul_cr_en, mul_mask, mul_data} = TBL[v];
      exp = predict(model);
      #1 check(TAG[v], exp);
      check("R2", exp);
      model = exp;
      @(negedge clk); idle();
      #1 check("R4", model);
    end

    // back-to-back random writes
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      exe_valid = 1'($urandom); exe_cr_en = 1'($urandom);
      mul_valid = 1'($urandom); mul_cr_en = 1'($urandom);
      exe_mask = NF'($urandom); mul_mask = NF'($urandom);
      exe_data = $urandom; mul_data = $urandom;
      exp = predict(model);
      #1 check("R3", exp);
      model = exp;
    end
    @(negedge clk); idle();
    #1 check("R4", model);

    // reset while a write is requested clears storage
    @(negedge clk);
    exe_valid = 1; exe_cr_en = 1; exe_mask = 8'hFF; exe_data = 32'hDEAD_BEEF;
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; idle(); model = '0;
    #1 check("R1", '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule